// File: doc/BRIEF.md
# Dual-Channel Up/Down Pulse Counter

This block keeps a signed count that moves up or down as edges arrive on two input channels. Each channel has an edge input and a level control input. The edge input chooses a step for its rising edges and a separate step for its falling edges. The level of the control input then keeps that step, reverses its direction, or blocks it. Both channels add into the same counter in the same cycle.

Every raw input can be inverted, and it then passes through a two-flop synchronizer. An optional filter rejects level changes that are too short. The count can be frozen or forced to zero. When the count reaches a programmed negative or positive bound, it returns to zero and raises a strobe for one cycle.

The typical use is to decode a quadrature encoder. Each phase drives one channel's edge input and the other channel's control input. The two channels are given opposite edge steps, and the unit then counts four steps per encoder cycle, with the sign giving the direction.

Top module: `pulse_count_unit`

## Requirements
- R1: After reset, `count` is 0 and `limit_hit` is 0.
- R2: Each channel has a 2-bit step code for rising edges and another for falling edges. Code 0 holds, 1 adds one, 2 subtracts one and 3 holds. Channel i uses bits [2i+1:2i] of `rise_step` and `fall_step`.
- R3: Each channel has a 2-bit modifier for control low (`mod_lo`) and another for control high (`mod_hi`), taken from bits [2i+1:2i]. The control level in the same cycle as the edge selects which one applies. Code 0 keeps the step, 1 reverses its sign, and 2 or 3 suppresses it.
- R4: Bit i of `sig_inv` inverts edge input i before use, and bit i of `ctl_inv` inverts control input i before use.
- R5: The steps of all channels in one cycle are summed, so opposite steps cancel and equal steps add.
- R6: If the next count would be at or beyond `lim_hi` or at or beyond `lim_lo`, the count becomes 0 instead and `limit_hit` is high for exactly the following cycle.
- R7: With `filt_en` high, a synchronized level must hold for `filt_thr` consecutive cycles before it is accepted. A shorter pulse produces no count.
- R8: With `filt_en` low, a raw edge changes `count` on the third rising clock edge after the input changes, and never sooner.
- R9: While `pause` is high and `clr` is low, `count` does not change.
- R10: While `clr` is high, `count` is 0 from the next cycle on. `clr` has priority over `pause` and over counting.
- R11: Encoder decoding works with this setting: channel 0 has edge=A, control=B, rise step 2, fall step 1. Channel 1 has edge=B, control=A, rise step 1, fall step 2. Both channels use low modifier 1 and high modifier 0. With this setting, one full forward A/B cycle adds 4 and one reverse cycle subtracts 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 2 | Raw edge inputs, one per channel |
| ctl_in | input | 2 | Raw control-level inputs, one per channel |
| sig_inv | input | 2 | Invert edge input per channel |
| ctl_inv | input | 2 | Invert control input per channel |
| rise_step | input | 4 | Rising-edge step code, 2 bits per channel |
| fall_step | input | 4 | Falling-edge step code, 2 bits per channel |
| mod_lo | input | 4 | Modifier used while control is low, 2 bits per channel |
| mod_hi | input | 4 | Modifier used while control is high, 2 bits per channel |
| filt_en | input | 1 | Glitch filter enable |
| filt_thr | input | 10 | Filter hold time in cycles |
| lim_lo | input | 16 | Signed lower wrap bound (negative) |
| lim_hi | input | 16 | Signed upper wrap bound (positive) |
| pause | input | 1 | Freeze the count |
| clr | input | 1 | Force the count to zero while high |
| count | output | 16 | Signed count value |
| limit_hit | output | 1 | One-cycle strobe when a bound is reached |

## Verification
The bench checks every step code under both control levels and every modifier. A design that mixed up the reverse and suppress codes, or read the wrong control level, would get the sign of the step wrong. It drives a rising edge on both channels with opposite steps to make sure they cancel rather than letting one channel win. It walks the count onto each bound to confirm the wrap to zero and that the strobe lasts one cycle. A design that saturated, or left the strobe high, would fail there. It sends a pulse just shorter than the filter time, which a missing filter would count, and it measures the exact latency with the filter off so that a missing or extra synchronizer stage shows up.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD  = 2'd0,
      STEP_UP    = 2'd1,
      STEP_DOWN  = 2'd2,
      STEP_HOLD3 = 2'd3
   } step_code_e;

   typedef enum logic [1:0] {
      MOD_KEEP  = 2'd0,
      MOD_FLIP  = 2'd1,
      MOD_BLOCK = 2'd2,
      MOD_BLK3  = 2'd3
   } mod_code_e;
endpackage

// File: rtl/pcu_input_cond.sv
module pcu_input_cond #(
   parameter int THR_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw,
   input  logic             inv,
   input  logic             filt_en,
   input  logic [THR_W-1:0] filt_thr,
   output logic             clean
);
   logic             s1_q, s2_q, held_q;
   logic [THR_W-1:0] run_q;

   // inversion ahead of the two synchronizer flops
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q <= 1'b0;
         s2_q <= 1'b0;
      end else begin
         s1_q <= raw ^ inv;
         s2_q <= s1_q;
      end
   end

   // accept a new level only after it has persisted filt_thr cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_q <= 1'b0;
         run_q  <= '0;
      end else if (!filt_en) begin
         held_q <= s2_q;
         run_q  <= '0;
      end else if (s2_q == held_q) begin
         run_q  <= '0;
      end else if (({1'b0, run_q} + 1'b1) >= {1'b0, filt_thr}) begin
         held_q <= s2_q;
         run_q  <= '0;
      end else begin
         run_q  <= run_q + 1'b1;
      end
   end

   assign clean = filt_en ? held_q : s2_q;
endmodule

// File: rtl/pcu_channel.sv
module pcu_channel
   import pcu_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sig_c,
   input  logic       ctl_c,
   input  logic [1:0] rise_code,
   input  logic [1:0] fall_code,
   input  logic [1:0] lo_code,
   input  logic [1:0] hi_code,
   output logic [1:0] step
);
   logic       prev_q;
   logic       rise, fall;
   step_code_e act;
   mod_code_e  modc;
   logic [1:0] base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig_c;
   end

   assign rise = sig_c & ~prev_q;
   assign fall = ~sig_c & prev_q;

   always_comb begin
      if (rise)      act = step_code_e'(rise_code);
      else if (fall) act = step_code_e'(fall_code);
      else           act = STEP_HOLD;
      modc = mod_code_e'(ctl_c ? hi_code : lo_code);
      case (act)
         STEP_UP:   base = 2'b01;
         STEP_DOWN: base = 2'b11;
         default:   base = 2'b00;
      endcase
      case (modc)
         MOD_KEEP: step = base;
         MOD_FLIP: step = 2'b00 - base;
         default:  step = 2'b00;
      endcase
   end
endmodule

// File: rtl/pulse_count_unit.sv
module pulse_count_unit #(
   parameter int N_CH  = 2,
   parameter int CNT_W = 16,
   parameter int THR_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CH-1:0]    sig_in,
   input  logic [N_CH-1:0]    ctl_in,
   input  logic [N_CH-1:0]    sig_inv,
   input  logic [N_CH-1:0]    ctl_inv,
   input  logic [2*N_CH-1:0]  rise_step,
   input  logic [2*N_CH-1:0]  fall_step,
   input  logic [2*N_CH-1:0]  mod_lo,
   input  logic [2*N_CH-1:0]  mod_hi,
   input  logic               filt_en,
   input  logic [THR_W-1:0]   filt_thr,
   input  logic [CNT_W-1:0]   lim_lo,
   input  logic [CNT_W-1:0]   lim_hi,
   input  logic               pause,
   input  logic               clr,
   output logic [CNT_W-1:0]   count,
   output logic               limit_hit
);
   localparam int SUM_W = $clog2(N_CH + 1) + 2;
   localparam int EXT_W = CNT_W + 1;

   if (N_CH < 1)            begin : g_bad_ch  $error("N_CH must be at least 1"); end
   if (CNT_W < 4)           begin : g_bad_cnt $error("CNT_W must be at least 4"); end
   if (THR_W < 1)           begin : g_bad_thr $error("THR_W must be at least 1"); end
   if (EXT_W <= SUM_W)      begin : g_bad_sum $error("CNT_W too small for N_CH"); end

   logic [1:0] step [N_CH];

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      logic sig_c, ctl_c;
      pcu_input_cond #(.THR_W(THR_W)) u_sig (
         .clk(clk), .rst_n(rst_n), .raw(sig_in[i]), .inv(sig_inv[i]),
         .filt_en(filt_en), .filt_thr(filt_thr), .clean(sig_c));
      pcu_input_cond #(.THR_W(THR_W)) u_ctl (
         .clk(clk), .rst_n(rst_n), .raw(ctl_in[i]), .inv(ctl_inv[i]),
         .filt_en(filt_en), .filt_thr(filt_thr), .clean(ctl_c));
      pcu_channel u_chan (
         .clk(clk), .rst_n(rst_n), .sig_c(sig_c), .ctl_c(ctl_c),
         .rise_code(rise_step[2*i +: 2]), .fall_code(fall_step[2*i +: 2]),
         .lo_code(mod_lo[2*i +: 2]), .hi_code(mod_hi[2*i +: 2]),
         .step(step[i]));
   end

   logic signed [SUM_W-1:0] sum;
   logic signed [EXT_W-1:0] nxt, lo_x, hi_x;
   logic [CNT_W-1:0]        cnt_q;
   logic                    hit_q;

   always_comb begin
      sum = '0;
      for (int i = 0; i < N_CH; i++)
         sum = sum + {{(SUM_W-2){step[i][1]}}, step[i]};
   end

   assign nxt  = {cnt_q[CNT_W-1], cnt_q} + {{(EXT_W-SUM_W){sum[SUM_W-1]}}, sum};
   assign lo_x = {lim_lo[CNT_W-1], lim_lo};
   assign hi_x = {lim_hi[CNT_W-1], lim_hi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         hit_q <= 1'b0;
      end else begin
         hit_q <= 1'b0;
         if (clr) begin
            cnt_q <= '0;
         end else if (!pause && sum != '0) begin
            if (nxt >= hi_x || nxt <= lo_x) begin
               cnt_q <= '0;
               hit_q <= 1'b1;
            end else begin
               cnt_q <= nxt[CNT_W-1:0];
            end
         end
      end
   end

   assign count     = cnt_q;
   assign limit_hit = hit_q;
endmodule

// File: rtl/pcu_chk.sv
module pcu_chk #(
   parameter int N_CH  = 2,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pause,
   input logic             clr,
   input logic [CNT_W-1:0] count,
   input logic             limit_hit
);
   logic [CNT_W-1:0]     prev_q;
   logic                 clr_q, valid_q;
   logic signed [CNT_W:0] delta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         clr_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         prev_q  <= count;
         clr_q   <= clr;
         valid_q <= 1'b1;
      end
   end

   assign delta = $signed({count[CNT_W-1], count}) - $signed({prev_q[CNT_W-1], prev_q});

   // R1
   reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q |-> (count == '0 && !limit_hit));
   // R10
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> count == '0);
   // R9
   pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pause && !clr) |=> $stable(count));
   // R6
   wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      limit_hit |-> count == '0);
   // R5
   step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !clr_q && count != '0) |-> (delta <= N_CH && delta >= -N_CH));
endmodule

bind pulse_count_unit pcu_chk #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pause(pause), .clr(clr),
   .count(count), .limit_hit(limit_hit));

// File: tb/sim_pulse_count_unit.sv
module sim_pulse_count_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  sig_in = '0, ctl_in = '0, sig_inv = '0, ctl_inv = '0;
   logic [3:0]  rise_step = '0, fall_step = '0, mod_lo = '0, mod_hi = '0;
   logic        filt_en = 1'b0;
   logic [9:0]  filt_thr = '0;
   logic [15:0] lim_lo = -16'sd100, lim_hi = 16'sd100;
   logic        pause = 1'b0, clr = 1'b0;
   logic [15:0] count;
   logic        limit_hit;
   int          n_chk = 0, n_err = 0;
   int          ref_cnt = 0;
   bit          done = 0;

   always #10 clk = ~clk;

   pulse_count_unit u0 (.*);

   // rise, fall, lo, hi, ctl, is_rise, delta(2b signed)
   localparam logic [11:0] VEC [12] = '{
      {2'd1, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 2'b01},
      {2'd2, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 2'b11},
      {2'd0, 2'd1, 2'd0, 2'd0, 1'b0, 1'b1, 2'b00},
      {2'd0, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 2'b01},
      {2'd0, 2'd2, 2'd0, 2'd0, 1'b0, 1'b0, 2'b11},
      {2'd1, 2'd0, 2'd1, 2'd0, 1'b0, 1'b1, 2'b11},
      {2'd2, 2'd0, 2'd1, 2'd0, 1'b0, 1'b1, 2'b01},
      {2'd1, 2'd0, 2'd0, 2'd2, 1'b1, 1'b1, 2'b00},
      {2'd1, 2'd0, 2'd0, 2'd1, 1'b1, 1'b1, 2'b11},
      {2'd3, 2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 2'b00},
      {2'd0, 2'd2, 2'd0, 2'd0, 1'b1, 1'b0, 2'b11},
      {2'd1, 2'd0, 2'd3, 2'd0, 1'b0, 1'b1, 2'b00}
   };

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic chk_cnt(string req);
      chk(req, int'($signed(count)), ref_cnt);
   endtask

   task automatic quiet_all();
      rise_step = '0; fall_step = '0; mod_lo = '0; mod_hi = '0;
   endtask

   task automatic do_clear();
      clr = 1'b1; tick(2); clr = 1'b0; ref_cnt = 0; tick(1);
   endtask

   task automatic enc(logic a, logic b);
      sig_in[0] = a; ctl_in[1] = a; sig_in[1] = b; ctl_in[0] = b; tick(6);
   endtask

   initial begin
      tick(3);
      // R1 reset state
      chk("R1 count", int'(count), 0);
      chk("R1 limit_hit", int'(limit_hit), 0);
      rst_n = 1'b1;
      tick(4);

      // R2 R3 table of step codes and modifiers on channel 0
      foreach (VEC[k]) begin
         logic [11:0] v;
         v = VEC[k];
         quiet_all();
         ctl_in[0] = v[3];
         sig_in[0] = ~v[2];
         tick(6);
         rise_step[1:0] = v[11:10]; fall_step[1:0] = v[9:8];
         mod_lo[1:0] = v[7:6]; mod_hi[1:0] = v[5:4];
         tick(2);
         sig_in[0] = v[2];
         tick(6);
         ref_cnt += v[1] ? -1 : (v[0] ? 1 : 0);
         chk_cnt($sformatf("R2/R3 vector %0d", k));
      end

      // R8 latency with filter off
      quiet_all(); sig_in[0] = 1'b0; tick(6);
      rise_step[1:0] = 2'd1;
      sig_in[0] = 1'b1; tick(2);
      chk_cnt("R8 no change after two edges");
      tick(1); ref_cnt += 1;
      chk_cnt("R8 change on third edge");

      // R4 edge inversion: raw fall becomes internal rise
      quiet_all(); sig_inv[0] = 1'b1; sig_in[0] = 1'b1; tick(6);
      rise_step[1:0] = 2'd1;
      sig_in[0] = 1'b0; tick(6); ref_cnt += 1;
      chk_cnt("R4 edge inverted");
      // R4 control inversion: raw high reads as low, low modifier blocks
      quiet_all(); sig_inv[0] = 1'b0; sig_in[0] = 1'b0; ctl_inv[0] = 1'b1; ctl_in[0] = 1'b1; tick(6);
      rise_step[1:0] = 2'd1; mod_lo[1:0] = 2'd2;
      sig_in[0] = 1'b1; tick(6);
      chk_cnt("R4 control inverted");
      ctl_inv[0] = 1'b0; ctl_in[0] = 1'b0;

      // R5 two channels in the same cycle
      quiet_all(); sig_in = 2'b00; tick(6);
      rise_step = {2'd2, 2'd1};
      sig_in = 2'b11; tick(6);
      chk_cnt("R5 opposite steps cancel");
      quiet_all(); sig_in = 2'b00; tick(6);
      rise_step = {2'd1, 2'd1};
      sig_in = 2'b11; tick(6); ref_cnt += 2;
      chk_cnt("R5 equal steps add");

      // R7 filter
      quiet_all(); sig_in = 2'b00; tick(6);
      filt_en = 1'b1; filt_thr = 10'd5; tick(6);
      rise_step[1:0] = 2'd1; fall_step[1:0] = 2'd1;
      sig_in[0] = 1'b1; tick(3); sig_in[0] = 1'b0; tick(12);
      chk_cnt("R7 short pulse ignored");
      sig_in[0] = 1'b1; tick(8); sig_in[0] = 1'b0; tick(12); ref_cnt += 2;
      chk_cnt("R7 long pulse counted");
      filt_en = 1'b0; filt_thr = '0;

      // R9 pause
      quiet_all(); sig_in = 2'b00; tick(6);
      rise_step[1:0] = 2'd1; pause = 1'b1;
      sig_in[0] = 1'b1; tick(6);
      chk_cnt("R9 paused");
      // R10 clear, with priority over pause
      clr = 1'b1; tick(2); ref_cnt = 0;
      chk_cnt("R10 clear while paused");
      pause = 1'b0; sig_in[0] = 1'b0; tick(2); sig_in[0] = 1'b1; tick(6);
      chk_cnt("R10 clear held blocks count");
      clr = 1'b0; tick(1);

      // R6 upper and lower wrap
      quiet_all(); sig_in = 2'b00; tick(6);
      lim_hi = 16'sd5; lim_lo = -16'sd3;
      do_clear();
      rise_step[1:0] = 2'd1; fall_step[1:0] = 2'd1;
      for (int j = 0; j < 4; j++) begin
         sig_in[0] = ~sig_in[0]; tick(6);
      end
      ref_cnt = 4;
      chk_cnt("R6 below upper bound");
      sig_in[0] = ~sig_in[0]; tick(3); ref_cnt = 0;
      chk_cnt("R6 wrap at upper bound");
      chk("R6 strobe high", int'(limit_hit), 1);
      tick(1);
      chk("R6 strobe one cycle", int'(limit_hit), 0);
      rise_step[1:0] = 2'd2; fall_step[1:0] = 2'd2;
      for (int j = 0; j < 2; j++) begin
         sig_in[0] = ~sig_in[0]; tick(6);
      end
      ref_cnt = -2;
      chk_cnt("R6 above lower bound");
      sig_in[0] = ~sig_in[0]; tick(3); ref_cnt = 0;
      chk_cnt("R6 wrap at lower bound");
      chk("R6 strobe low bound", int'(limit_hit), 1);
      lim_hi = 16'sd100; lim_lo = -16'sd100;

      // R11 encoder decode
      quiet_all(); sig_in = 2'b00; ctl_in = 2'b00; tick(6);
      do_clear();
      rise_step = {2'd1, 2'd2}; fall_step = {2'd2, 2'd1};
      mod_lo = {2'd1, 2'd1}; mod_hi = {2'd0, 2'd0};
      enc(1, 0); enc(1, 1); enc(0, 1); enc(0, 0);
      ref_cnt = 4;
      chk_cnt("R11 forward cycle");
      enc(0, 1); enc(1, 1); enc(1, 0); enc(0, 0);
      enc(0, 1); enc(1, 1); enc(1, 0); enc(0, 0);
      ref_cnt = -4;
      chk_cnt("R11 reverse cycles");

      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule